// File: doc/BRIEF.md
# Link Synchronization Request Generator

This block sits on the receive side of a multi-gigabit serial link that uses 8b/10b control characters. Each cycle it may take one decoded character, which comes with a control flag and markers for the last character of a frame and of a multiframe. From these it drives the synchronization request back to the transmitter. While the request is raised, the transmitter sends comma characters (K28.5). The block counts consecutive commas, and once the run is long enough it drops the request and waits for the first non-comma character, which marks the start of the alignment sequence.

After that point the block checks where frame alignment characters (K28.7) and multiframe alignment characters (K28.3) arrive. A frame marker is legal only on the last character of a frame. A multiframe marker is legal only on the last character of a multiframe. An alignment character in any other position raises the request again. The request is then held for a set number of frames, longer than four, which forces the transmitter to resynchronize. After the hold, the block goes back to counting commas. A saturating counter records how many misplaced alignment characters have been seen. A state output reports the link phase: 0 = synchronizing, 1 = aligning, 2 = locked, 3 = holding a resync request.

Top module: `srg_sync_request`

## Requirements
- R1: After reset, `sync_req` is 1, `link_state` is 0 (synchronizing) and `realign_errs` is 0.
- R2: In synchronizing, the edge that samples the LOCK_RUN-th consecutive valid comma (control flag 1, data 0xBC) moves the block to aligning (1). From the next cycle, `sync_req` reads 0.
- R3: In synchronizing, any valid non-comma character resets the comma run to zero. Cycles with `ch_valid` low neither advance nor break the run.
- R4: In aligning, valid commas keep the state. The first valid non-comma character that is not a misplaced alignment character moves the block to locked (2).
- R5: In aligning or locked, a valid frame marker (control flag 1, data 0xFC) with `ch_frame_end` low moves the block to holding (3), with `sync_req` 1. With `ch_frame_end` high, the same character leaves the state unchanged.
- R6: In aligning or locked, a valid multiframe marker (control flag 1, data 0x7C) with `ch_mframe_end` low moves the block to holding with `sync_req` 1. With `ch_mframe_end` high, the same character leaves the state unchanged.
- R7: In holding, `sync_req` stays 1 until HOLD_FRAMES valid characters with `ch_frame_end` high have been received. The edge that samples the last of them returns the block to synchronizing with an empty comma run.
- R8: Each misplaced alignment character seen in aligning or locked adds one to `realign_errs`. The counter saturates at 2^ERR_W-1.
- R9: In holding, a misplaced alignment character does not change `realign_errs` and does not restart the hold. It still counts as a frame end if `ch_frame_end` is high.
- R10: A data character (control flag 0) whose value is 0xFC or 0x7C is never treated as an alignment character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_valid | input | 1 | A decoded character is present this cycle |
| ch_data | input | 8 | Decoded octet |
| ch_is_k | input | 1 | Character is a control character |
| ch_frame_end | input | 1 | Character is the last of its frame |
| ch_mframe_end | input | 1 | Character is the last of its multiframe |
| sync_req | output | 1 | Synchronization request to the transmitter, active high |
| link_state | output | 2 | 0 synchronizing, 1 aligning, 2 locked, 3 holding |
| realign_errs | output | ERR_W | Saturating count of misplaced alignment characters |

## Verification
During a hold, one character can both end a frame, which advances the hold count, and be a misplaced alignment character, which in the other phases would count an error and start a hold. The bench provokes this by sending a multiframe marker on a frame end that is not a multiframe end, in the middle of a hold. A correct result leaves the error count unchanged, does not restart the hold, and returns to synchronizing exactly after the fifth frame end. A second collision is a misplaced character that arrives when the error counter is already at its maximum. The bench drives enough resync cycles to reach that point, and checks that the hold is still entered while the count stays at its ceiling.

// File: rtl/srg_pkg.sv
package srg_pkg;

    localparam logic [7:0] K_COMMA = 8'hBC;
    localparam logic [7:0] K_FMARK = 8'hFC;
    localparam logic [7:0] K_AMARK = 8'h7C;

    typedef enum logic [1:0] {
        ST_SYNC   = 2'd0,
        ST_ALIGN  = 2'd1,
        ST_LOCKED = 2'd2,
        ST_HOLD   = 2'd3
    } link_state_e;

    typedef struct packed {
        logic valid;
        logic comma;
        logic frame_end;
        logic misplaced;
    } char_class_t;

    function automatic char_class_t classify(
        input logic       valid,
        input logic [7:0] data,
        input logic       is_k,
        input logic       fend,
        input logic       mfend
    );
        char_class_t c;
        logic fmark;
        logic amark;
        fmark       = is_k && (data == K_FMARK);
        amark       = is_k && (data == K_AMARK);
        c.valid     = valid;
        c.comma     = valid && is_k && (data == K_COMMA);
        c.frame_end = valid && fend;
        c.misplaced = valid && ((fmark && !fend) || (amark && !mfend));
        return c;
    endfunction

endpackage

// File: rtl/srg_char_classify.sv
module srg_char_classify
    import srg_pkg::*;
(
    input  logic        ch_valid,
    input  logic [7:0]  ch_data,
    input  logic        ch_is_k,
    input  logic        ch_frame_end,
    input  logic        ch_mframe_end,
    output char_class_t cls
);
    always_comb begin
        cls = classify(ch_valid, ch_data, ch_is_k, ch_frame_end, ch_mframe_end);
    end
endmodule

// File: rtl/srg_comma_run.sv
module srg_comma_run #(
    parameter int LOCK_RUN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic valid,
    input  logic comma,
    output logic run_done
);
    localparam int CW = $clog2(LOCK_RUN + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_RUN - 1);

    logic [CW-1:0] run_q;

    assign run_done = enable && valid && comma && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_q <= '0;
        end else if (valid) begin
            if (!comma || run_done) run_q <= '0;
            else                    run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/srg_hold_timer.sv
module srg_hold_timer #(
    parameter int HOLD_FRAMES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic frame_end,
    output logic expire
);
    localparam int HW = $clog2(HOLD_FRAMES + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_FRAMES - 1);

    logic [HW-1:0] frames_q;

    assign expire = active && frame_end && (frames_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !active || expire) frames_q <= '0;
        else if (frame_end)           frames_q <= frames_q + 1'b1;
    end
endmodule

// File: rtl/srg_err_count.sv
module srg_err_count #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);
    localparam logic [ERR_W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                         count <= '0;
        else if (inc && (count != CMAX)) count <= count + 1'b1;
    end
endmodule

// File: rtl/srg_sync_request.sv
module srg_sync_request
    import srg_pkg::*;
#(
    parameter int LOCK_RUN    = 4,
    parameter int HOLD_FRAMES = 5,
    parameter int ERR_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ch_valid,
    input  logic [7:0]       ch_data,
    input  logic             ch_is_k,
    input  logic             ch_frame_end,
    input  logic             ch_mframe_end,
    output logic             sync_req,
    output logic [1:0]       link_state,
    output logic [ERR_W-1:0] realign_errs
);
    char_class_t cls;
    link_state_e state_q, state_d;
    logic        run_done, hold_expire, checking, err_inc;

    srg_char_classify u_cls (
        .ch_valid      (ch_valid),
        .ch_data       (ch_data),
        .ch_is_k       (ch_is_k),
        .ch_frame_end  (ch_frame_end),
        .ch_mframe_end (ch_mframe_end),
        .cls           (cls)
    );

    srg_comma_run #(.LOCK_RUN(LOCK_RUN)) u_run (
        .clk      (clk),
        .rst      (rst),
        .enable   (state_q == ST_SYNC),
        .valid    (cls.valid),
        .comma    (cls.comma),
        .run_done (run_done)
    );

    srg_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .active    (state_q == ST_HOLD),
        .frame_end (cls.frame_end),
        .expire    (hold_expire)
    );

    assign checking = (state_q == ST_ALIGN) || (state_q == ST_LOCKED);
    assign err_inc  = checking && cls.misplaced;

    srg_err_count #(.ERR_W(ERR_W)) u_err (
        .clk   (clk),
        .rst   (rst),
        .inc   (err_inc),
        .count (realign_errs)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC:   if (run_done) state_d = ST_ALIGN;
            ST_ALIGN: begin
                if (cls.misplaced)                 state_d = ST_HOLD;
                else if (cls.valid && !cls.comma)  state_d = ST_LOCKED;
            end
            ST_LOCKED: if (cls.misplaced) state_d = ST_HOLD;
            ST_HOLD:   if (hold_expire)   state_d = ST_SYNC;
            default:   state_d = ST_SYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SYNC;
        else     state_q <= state_d;
    end

    assign link_state = state_q;
    assign sync_req   = (state_q == ST_SYNC) || (state_q == ST_HOLD);
endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ch_valid,
    input logic [7:0]       ch_data,
    input logic             ch_is_k,
    input logic             ch_frame_end,
    input logic             ch_mframe_end,
    input logic             sync_req,
    input logic [1:0]       link_state,
    input logic [ERR_W-1:0] realign_errs
);
    logic comma_in, bad_in, in_check;
    assign comma_in = ch_valid && ch_is_k && (ch_data == 8'hBC);
    assign bad_in   = ch_valid && ch_is_k &&
                      (((ch_data == 8'hFC) && !ch_frame_end) ||
                       ((ch_data == 8'h7C) && !ch_mframe_end));
    assign in_check = (link_state == 2'd1) || (link_state == 2'd2);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (sync_req && link_state == 2'd0 && realign_errs == '0)); // R1

    AST_ALIGN_NEEDS_COMMA: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd0 && !comma_in) |=> (link_state == 2'd0)); // R3

    AST_RELEASE_IN_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd1) |-> !sync_req); // R2

    AST_MISPLACED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (in_check && bad_in) |=> (link_state == 2'd3 && sync_req)); // R5

    AST_ERR_STEADY: assert property (@(posedge clk) disable iff (rst)
        !(in_check && bad_in) |=> $stable(realign_errs)); // R9

    AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_check && bad_in && realign_errs != '1) |=>
        (realign_errs == $past(realign_errs) + 1'b1)); // R8

    AST_HOLD_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd3 && !(ch_valid && ch_frame_end)) |=> (link_state == 2'd3)); // R7
endmodule

bind srg_sync_request srg_checker #(.ERR_W(ERR_W)) u_chk (.*);

// File: tb/srg_sync_request_bench.sv
module srg_sync_request_bench;
    localparam int EW   = 3;
    localparam int RUN  = 4;
    localparam int HOLD = 5;
    localparam int EMAX = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ch_valid = 1'b0;
    logic [7:0]    ch_data = 8'h00;
    logic          ch_is_k = 1'b0;
    logic          ch_frame_end = 1'b0;
    logic          ch_mframe_end = 1'b0;
    logic          sync_req;
    logic [1:0]    link_state;
    logic [EW-1:0] realign_errs;

    int    n_tests = 0;
    int    n_fail  = 0;
    string tag     = "R1";
    bit    done    = 1'b0;

    int m_st = 0, m_run = 0, m_hold = 0, m_err = 0;

    always #4 clk = ~clk;

    srg_sync_request #(.LOCK_RUN(RUN), .HOLD_FRAMES(HOLD), .ERR_W(EW)) u_srg_sync_request (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data), .ch_is_k(ch_is_k),
        .ch_frame_end(ch_frame_end), .ch_mframe_end(ch_mframe_end),
        .sync_req(sync_req), .link_state(link_state), .realign_errs(realign_errs)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit comma, bad;
        comma = ch_is_k && ch_data == 8'hBC;
        bad   = ch_is_k && ((ch_data == 8'hFC && !ch_frame_end) ||
                            (ch_data == 8'h7C && !ch_mframe_end));
        if (rst) begin
            m_st = 0; m_run = 0; m_hold = 0; m_err = 0;
        end else if (ch_valid) begin
            case (m_st)
                0: begin
                    if (!comma) m_run = 0;
                    else if (m_run == RUN - 1) begin m_run = 0; m_st = 1; end
                    else m_run++;
                end
                1, 2: begin
                    if (bad) begin
                        m_st = 3; m_hold = 0;
                        if (m_err < EMAX) m_err++;
                    end else if (m_st == 1 && !comma) m_st = 2;
                end
                default: begin
                    if (ch_frame_end) begin
                        if (m_hold == HOLD - 1) begin m_st = 0; m_hold = 0; m_run = 0; end
                        else m_hold++;
                    end
                end
            endcase
        end
    end

    task automatic compare();
        bit exp_req;
        exp_req = (m_st == 0 || m_st == 3);
        n_tests++;
        if (sync_req !== exp_req) begin
            n_fail++;
            $display("FAIL %s sync_req actual %0b expected %0b", tag, sync_req, exp_req);
        end
        n_tests++;
        if (link_state !== 2'(m_st)) begin
            n_fail++;
            $display("FAIL %s link_state actual %0d expected %0d", tag, link_state, m_st);
        end
        n_tests++;
        if (realign_errs !== EW'(m_err)) begin
            n_fail++;
            $display("FAIL %s realign_errs actual %0d expected %0d", tag, realign_errs, m_err);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] d, input bit k, input bit fe, input bit mfe);
        @(negedge clk);
        compare();
        ch_valid = v; ch_data = d; ch_is_k = k; ch_frame_end = fe; ch_mframe_end = mfe;
    endtask

    task automatic expect_state(input int st, input string why);
        @(negedge clk);
        n_tests++;
        if (link_state !== 2'(st)) begin
            n_fail++;
            $display("FAIL %s %s link_state actual %0d expected %0d", tag, why, link_state, st);
        end
        ch_valid = 1'b0;
    endtask

    task automatic comma();
        step(1, 8'hBC, 1, 0, 0);
    endtask

    task automatic relock();
        for (int i = 0; i < RUN; i++) comma();
        step(1, 8'h1C, 1, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired in %s", tag);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        step(0, 8'h00, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        @(negedge clk); compare(); rst = 1'b0;
        step(0, 8'h00, 0, 0, 0);

        tag = "R3";
        comma(); comma(); comma();
        step(1, 8'h11, 0, 0, 0);
        comma(); comma();
        step(0, 8'hBC, 1, 0, 0);
        comma();
        step(0, 8'h00, 0, 0, 0);
        expect_state(0, "run broken by data");

        tag = "R2";
        comma();
        step(0, 8'h00, 0, 0, 0);
        expect_state(1, "run complete");

        tag = "R4";
        comma(); comma();
        step(1, 8'h1C, 1, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        expect_state(2, "first non-comma");

        tag = "R5";
        step(1, 8'h21, 0, 0, 0);
        step(1, 8'hFC, 1, 1, 0);
        tag = "R6";
        step(1, 8'h22, 0, 0, 0);
        step(1, 8'h7C, 1, 1, 1);
        tag = "R10";
        step(1, 8'hFC, 0, 0, 0);
        step(1, 8'h7C, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        expect_state(2, "data octets look like markers");

        tag = "R5";
        step(1, 8'hFC, 1, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        expect_state(3, "frame marker off frame end");

        tag = "R9";
        for (int f = 0; f < HOLD; f++) begin
            step(1, 8'h7C, 1, 0, 0);
            if (f == 2) step(1, 8'h7C, 1, 1, 0);
            else        step(1, 8'h33, 0, 1, 0);
            tag = (f == HOLD - 1) ? "R7" : "R9";
        end
        step(0, 8'h00, 0, 0, 0);
        expect_state(0, "hold over");

        tag = "R6";
        relock();
        step(1, 8'h7C, 1, 1, 0);
        step(0, 8'h00, 0, 0, 0);
        expect_state(3, "mframe marker off mframe end");

        tag = "R8";
        for (int r = 0; r < EMAX + 3; r++) begin
            for (int f = 0; f < HOLD; f++) step(1, 8'h44, 0, 1, 0);
            relock();
            step(1, 8'hFC, 1, 0, 0);
        end
        step(0, 8'h00, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        @(negedge clk);
        n_tests++;
        if (realign_errs !== EW'(EMAX)) begin
            n_fail++;
            $display("FAIL R8 saturation actual %0d expected %0d", realign_errs, EMAX);
        end

        tag = "R1";
        rst = 1'b1;
        step(0, 8'h00, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        rst = 1'b0;
        step(0, 8'h00, 0, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule